// File: doc/BRIEF.md
# Store-Miss Line Fill Tracker

This block keeps track of cache line fetches started by store misses that are allowed to allocate a line. A store miss arrives with its word address, its 32-bit data and its byte enables. The block compares the line address with every fill still in flight. A miss to a line that is not yet being fetched takes a free fill slot, and the block issues one read request for the whole 32-byte line. A miss to a line that is already being fetched takes a slot in a separate pending buffer and issues no second read.

Memory returns the eight 32-bit words of a line one at a time, in any order. Each response carries the fill slot and the word position it belongs to. When the last missing word lands, the block emits the complete line toward the cache array in a single cycle. The store bytes from the first miss and from every pending miss to that line are already merged into it. The same edge frees the fill slot and all the pending slots tied to it.

A requester is held off by a stall output whenever the buffer it needs is full. Stores that may not allocate (not cacheable, or without write allocation) pass through without effect here.

Top module: `line_fill_ctrl`

## Requirements
- R1: After a synchronous active-high reset, no fill or pending slot is occupied, and `rd_valid`, `line_valid` and `req_stall` are low.
- R2: A request with `req_cacheable`=0 or `req_walloc`=0 is never stalled, never causes a read request and occupies no slot, so a later allocating miss to the same line starts its own fetch.
- R3: An accepted allocating miss whose line (`req_waddr[ADDR_W-3:3]`) matches no outstanding fill takes the lowest-numbered free fill slot. In the next cycle `rd_valid` is high for one cycle, with `rd_line` set to that line and `rd_idx` set to that slot.
- R4: An accepted allocating miss whose line matches an outstanding fill takes a pending slot and causes no read request. At most one fill is outstanding per line.
- R5: `req_stall` is high, and the request is not taken, exactly when an allocating miss arrives and the buffer it needs has no free slot. A new line needs the fill buffer and a matching line needs the pending buffer. Occupancy is counted as it stood before the current edge.
- R6: A response writes `rsp_data` into word `rsp_word` of fill slot `rsp_idx`. Words may arrive in any order, and a repeated word overwrites the earlier one. `line_valid` stays low until all eight positions have been received.
- R7: One cycle after the response that completes a line, `line_valid` is high for one cycle. `line_addr` gives the line, and word w of `line_data` sits at bits [32w+31:32w]. Each byte written by an accepted store of that line holds the data of the latest such store, and every other byte holds the returned data.
- R8: Completion frees the fill slot and all its pending slots on the same edge, so they can be taken in the next cycle. An allocating miss to that line in the same cycle as the completing response counts as a new line and starts a new fetch.
- R9: Word position within the line is `req_waddr[2:0]`, and enable bit b of `req_be` selects byte lane `req_data[8b+7:8b]` of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store miss presented |
| req_waddr | input | ADDR_W-2 | Word address of the store |
| req_data | input | 32 | Store data |
| req_be | input | 4 | Byte enables of the store |
| req_cacheable | input | 1 | Access is cacheable |
| req_walloc | input | 1 | Page selects allocation on write |
| req_stall | output | 1 | Request not taken this cycle; hold and retry |
| rd_valid | output | 1 | Line read request pulse |
| rd_line | output | ADDR_W-5 | Line address to fetch |
| rd_idx | output | clog2(FILL_DEPTH) | Fill slot the response must name |
| rsp_valid | input | 1 | Returned word present |
| rsp_idx | input | clog2(FILL_DEPTH) | Fill slot of the returned word |
| rsp_word | input | 3 | Word position within the line |
| rsp_data | input | 32 | Returned word |
| line_valid | output | 1 | Completed line pulse |
| line_addr | output | ADDR_W-5 | Address of the completed line |
| line_data | output | 256 | Completed line with stores merged |

## Verification
The bench builds the block with four fill slots and three pending slots. Because the two depths differ, a stall caused by the wrong buffer, or a pending count compared against the fill depth, shows up as a mismatch. The small depths let directed sequences fill each buffer within a handful of requests. They also make the case reachable where a line completes while every fill slot is taken and a store to that same line arrives in the same cycle. A randomized phase over six lines then mixes stalls, pending merges, non-allocating requests and out-of-order responses.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int LINE_BITS  = WORD_W * LINE_WORDS;
  localparam int LINE_BYTES = LINE_BITS / 8;

  typedef struct packed {
    logic [2:0]        wsel;
    logic [3:0]        be;
    logic [WORD_W-1:0] data;
  } store_t;

  function automatic logic [LINE_BITS-1:0] put_data(logic [LINE_BITS-1:0] d, store_t s);
    logic [LINE_BITS-1:0] r;
    r = d;
    for (int b = 0; b < 4; b++)
      if (s.be[b]) r[int'(s.wsel)*WORD_W + b*8 +: 8] = s.data[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [LINE_BYTES-1:0] put_mask(logic [LINE_BYTES-1:0] m, store_t s);
    logic [LINE_BYTES-1:0] r;
    r = m;
    for (int b = 0; b < 4; b++)
      if (s.be[b]) r[int'(s.wsel)*4 + b] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/lfc_pick.sv
module lfc_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/lfc_fill_tab.sv
module lfc_fill_tab
  import lfc_pkg::*;
#(
  parameter int FILL_DEPTH = 4,
  parameter int LW = 27,
  localparam int FIW = (FILL_DEPTH > 1) ? $clog2(FILL_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LW-1:0]         look_line,
  input  logic                  alloc_en,
  input  logic [FIW-1:0]        alloc_idx,
  input  logic [LW-1:0]         alloc_line,
  input  store_t                alloc_st,
  input  logic                  ovl_en,
  input  logic [FIW-1:0]        ovl_idx,
  input  store_t                ovl_st,
  input  logic                  rsp_valid,
  input  logic [FIW-1:0]        rsp_idx,
  input  logic [2:0]            rsp_word,
  input  logic [WORD_W-1:0]     rsp_data,
  output logic [FILL_DEPTH-1:0] ent_valid,
  output logic                  hit,
  output logic [FIW-1:0]        hit_idx,
  output logic                  done_now,
  output logic                  line_valid,
  output logic [LW-1:0]         line_addr,
  output logic [LINE_BITS-1:0]  line_data
);
  logic [FILL_DEPTH-1:0] v;
  logic [LW-1:0]         tag  [FILL_DEPTH];
  logic [7:0]            got  [FILL_DEPTH];
  logic [LINE_BITS-1:0]  wd   [FILL_DEPTH];
  logic [LINE_BITS-1:0]  od   [FILL_DEPTH];
  logic [LINE_BYTES-1:0] om   [FILL_DEPTH];
  logic [FILL_DEPTH-1:0] hv;
  logic [7:0]            got_new;
  logic [LINE_BITS-1:0]  fresh, merged;

  assign ent_valid = v;
  assign got_new   = got[rsp_idx] | (8'd1 << rsp_word);
  assign done_now  = rsp_valid && v[rsp_idx] && (&got_new);

  // An entry finishing this cycle no longer counts as a match
  for (genvar gi = 0; gi < FILL_DEPTH; gi++) begin : g_hit
    assign hv[gi] = v[gi] && (tag[gi] == look_line) &&
                    !(done_now && (rsp_idx == FIW'(gi)));
  end

  lfc_pick #(.N(FILL_DEPTH)) u_hit (.req(hv), .any(hit), .idx(hit_idx));

  always_comb begin
    fresh = wd[rsp_idx];
    fresh[int'(rsp_word)*WORD_W +: WORD_W] = rsp_data;
    for (int b = 0; b < LINE_BYTES; b++)
      merged[b*8 +: 8] = om[rsp_idx][b] ? od[rsp_idx][b*8 +: 8] : fresh[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < FILL_DEPTH; i++) begin
      if (rst) begin
        v[i]   <= 1'b0;
        got[i] <= '0;
      end else if (alloc_en && alloc_idx == FIW'(i)) begin
        v[i]   <= 1'b1;
        tag[i] <= alloc_line;
        got[i] <= '0;
        od[i]  <= put_data('0, alloc_st);
        om[i]  <= put_mask('0, alloc_st);
      end else begin
        if (ovl_en && ovl_idx == FIW'(i)) begin
          od[i] <= put_data(od[i], ovl_st);
          om[i] <= put_mask(om[i], ovl_st);
        end
        if (rsp_valid && rsp_idx == FIW'(i)) begin
          wd[i][int'(rsp_word)*WORD_W +: WORD_W] <= rsp_data;
          got[i] <= got_new;
          if (done_now) v[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_valid <= 1'b0;
    else     line_valid <= done_now;
    if (done_now) begin
      line_addr <= tag[rsp_idx];
      line_data <= merged;
    end
  end

  for (genvar ga = 0; ga < FILL_DEPTH; ga++) begin : g_pa
    for (genvar gb = ga + 1; gb < FILL_DEPTH; gb++) begin : g_pb
      AST_ONE_FILL_PER_LINE: assert property (@(posedge clk) disable iff (rst)
        !(v[ga] && v[gb] && tag[ga] == tag[gb])); // R4
    end
  end

  AST_RSP_TO_LIVE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> v[rsp_idx]); // R6

  AST_LINE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> $past(rsp_valid)); // R7

  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !v[alloc_idx]); // R5
endmodule

// File: rtl/lfc_pend_tab.sv
module lfc_pend_tab #(
  parameter int PEND_DEPTH = 4,
  parameter int FILL_DEPTH = 4,
  localparam int FIW = (FILL_DEPTH > 1) ? $clog2(FILL_DEPTH) : 1,
  localparam int PIW = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ins_en,
  input  logic [FIW-1:0]            ins_owner,
  input  logic                      rel_en,
  input  logic [FIW-1:0]            rel_owner,
  output logic                      full,
  output logic [PEND_DEPTH-1:0]     slot_v,
  output logic [PEND_DEPTH*FIW-1:0] owner_flat
);
  logic           free_any;
  logic [PIW-1:0] free_idx;

  lfc_pick #(.N(PEND_DEPTH)) u_free (.req(~slot_v), .any(free_any), .idx(free_idx));
  assign full = ~free_any;

  always_ff @(posedge clk) begin
    for (int i = 0; i < PEND_DEPTH; i++) begin
      if (rst) begin
        slot_v[i] <= 1'b0;
      end else begin
        if (rel_en && slot_v[i] && owner_flat[i*FIW +: FIW] == rel_owner)
          slot_v[i] <= 1'b0;
        if (ins_en && free_idx == PIW'(i)) begin
          slot_v[i] <= 1'b1;
          owner_flat[i*FIW +: FIW] <= ins_owner;
        end
      end
    end
  end

  AST_NO_INSERT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> !full); // R5
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FILL_DEPTH = 4,
  parameter int PEND_DEPTH = 4,
  localparam int LW  = ADDR_W - 5,
  localparam int FIW = (FILL_DEPTH > 1) ? $clog2(FILL_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-3:0]    req_waddr,
  input  logic [WORD_W-1:0]    req_data,
  input  logic [3:0]           req_be,
  input  logic                 req_cacheable,
  input  logic                 req_walloc,
  output logic                 req_stall,
  output logic                 rd_valid,
  output logic [LW-1:0]        rd_line,
  output logic [FIW-1:0]       rd_idx,
  input  logic                 rsp_valid,
  input  logic [FIW-1:0]       rsp_idx,
  input  logic [2:0]           rsp_word,
  input  logic [WORD_W-1:0]    rsp_data,
  output logic                 line_valid,
  output logic [LW-1:0]        line_addr,
  output logic [LINE_BITS-1:0] line_data
);
  logic [LW-1:0]            req_line;
  store_t                   req_st;
  logic                     alloc, acc_new, acc_pend;
  logic [FILL_DEPTH-1:0]    ent_valid;
  logic                     hit, done_now, free_any, pend_full;
  logic [FIW-1:0]           hit_idx, free_idx;
  logic [PEND_DEPTH-1:0]    slot_v;
  logic [PEND_DEPTH*FIW-1:0] owner_flat;

  assign req_line = req_waddr[ADDR_W-3:3];
  assign req_st   = '{wsel: req_waddr[2:0], be: req_be, data: req_data};
  assign alloc    = req_valid && req_cacheable && req_walloc;

  lfc_pick #(.N(FILL_DEPTH)) u_free (.req(~ent_valid), .any(free_any), .idx(free_idx));

  assign req_stall = alloc && (hit ? pend_full : !free_any);
  assign acc_new   = alloc && !req_stall && !hit;
  assign acc_pend  = alloc && !req_stall && hit;

  lfc_fill_tab #(.FILL_DEPTH(FILL_DEPTH), .LW(LW)) u_fill (
    .clk(clk), .rst(rst), .look_line(req_line),
    .alloc_en(acc_new), .alloc_idx(free_idx), .alloc_line(req_line), .alloc_st(req_st),
    .ovl_en(acc_pend), .ovl_idx(hit_idx), .ovl_st(req_st),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_word(rsp_word), .rsp_data(rsp_data),
    .ent_valid(ent_valid), .hit(hit), .hit_idx(hit_idx), .done_now(done_now),
    .line_valid(line_valid), .line_addr(line_addr), .line_data(line_data)
  );

  lfc_pend_tab #(.PEND_DEPTH(PEND_DEPTH), .FILL_DEPTH(FILL_DEPTH)) u_pend (
    .clk(clk), .rst(rst),
    .ins_en(acc_pend), .ins_owner(hit_idx),
    .rel_en(done_now), .rel_owner(rsp_idx),
    .full(pend_full), .slot_v(slot_v), .owner_flat(owner_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= acc_new;
    if (acc_new) begin
      rd_line <= req_line;
      rd_idx  <= free_idx;
    end
  end

  AST_READ_TARGET_LIVE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ent_valid[rd_idx]); // R3

  for (genvar gp = 0; gp < PEND_DEPTH; gp++) begin : g_own
    AST_PEND_OWNER_LIVE: assert property (@(posedge clk) disable iff (rst)
      slot_v[gp] |-> ent_valid[owner_flat[gp*FIW +: FIW]]); // R4
  end
endmodule

// File: tb/sim_line_fill_ctrl.sv
module sim_line_fill_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int FD  = 4;
  localparam int PD  = 3;
  localparam int LW  = AW - 5;
  localparam int FIW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 0, req_cacheable = 0, req_walloc = 0;
  logic [AW-3:0] req_waddr = '0;
  logic [31:0]   req_data = '0;
  logic [3:0]    req_be = '0;
  logic          rsp_valid = 0;
  logic [FIW-1:0] rsp_idx = '0;
  logic [2:0]    rsp_word = '0;
  logic [31:0]   rsp_data = '0;
  logic          req_stall, rd_valid, line_valid;
  logic [LW-1:0] rd_line, line_addr;
  logic [FIW-1:0] rd_idx;
  logic [255:0]  line_data;

  line_fill_ctrl #(.ADDR_W(AW), .FILL_DEPTH(FD), .PEND_DEPTH(PD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_waddr(req_waddr),
    .req_data(req_data), .req_be(req_be), .req_cacheable(req_cacheable),
    .req_walloc(req_walloc), .req_stall(req_stall), .rd_valid(rd_valid),
    .rd_line(rd_line), .rd_idx(rd_idx), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .rsp_word(rsp_word), .rsp_data(rsp_data), .line_valid(line_valid),
    .line_addr(line_addr), .line_data(line_data)
  );

  // behavioural reference state
  bit            m_v [FD];
  logic [LW-1:0] m_tag [FD];
  bit [7:0]      m_got [FD];
  logic [255:0]  m_w [FD];
  logic [255:0]  m_od [FD];
  logic [31:0]   m_om [FD];
  bit            p_v [PD];
  int            p_o [PD];

  bit            e_rd, e_lv;
  logic [LW-1:0] e_rd_line, e_la;
  int            e_rd_idx;
  logic [255:0]  e_ld;
  bit            c_alloc, c_hit, c_done, c_stall;
  int            c_hidx, c_fpick, c_ppick;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  task automatic chk(string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [LW-1:0] l, int w);
    return {l[23:0], 8'(w)} ^ 32'h5a3c_0000;
  endfunction

  function automatic logic [LW-1:0] line_of(int k);
    return LW'(27'h0_1000 + k * 27'h33);
  endfunction

  function void predict();
    c_alloc = req_valid && req_cacheable && req_walloc;
    c_done = 0;
    if (rsp_valid && m_v[rsp_idx] && ((m_got[rsp_idx] | (8'd1 << rsp_word)) == 8'hff))
      c_done = 1;
    c_hit = 0; c_hidx = 0;
    for (int i = 0; i < FD; i++)
      if (m_v[i] && m_tag[i] == req_waddr[AW-3:3] && !(c_done && int'(rsp_idx) == i)) begin
        c_hit = 1; c_hidx = i;
      end
    c_fpick = -1;
    for (int i = FD - 1; i >= 0; i--) if (!m_v[i]) c_fpick = i;
    c_ppick = -1;
    for (int i = PD - 1; i >= 0; i--) if (!p_v[i]) c_ppick = i;
    c_stall = c_alloc && (c_hit ? (c_ppick < 0) : (c_fpick < 0));
  endfunction

  task automatic st_put(int e);
    for (int b = 0; b < 4; b++)
      if (req_be[b]) begin
        m_od[e][int'(req_waddr[2:0])*32 + b*8 +: 8] = req_data[b*8 +: 8];
        m_om[e][int'(req_waddr[2:0])*4 + b] = 1'b1;
      end
  endtask

  task automatic apply();
    int k;
    e_rd = 0; e_lv = 0;
    if (rsp_valid) begin
      k = int'(rsp_idx);
      m_w[k][int'(rsp_word)*32 +: 32] = rsp_data;
      m_got[k] = m_got[k] | (8'd1 << rsp_word);
      if (c_done) begin
        e_lv = 1; e_la = m_tag[k];
        for (int b = 0; b < 32; b++)
          e_ld[b*8 +: 8] = m_om[k][b] ? m_od[k][b*8 +: 8] : m_w[k][b*8 +: 8];
        m_v[k] = 0;
        for (int p = 0; p < PD; p++) if (p_v[p] && p_o[p] == k) p_v[p] = 0;
      end
    end
    if (c_alloc && !c_stall) begin
      if (c_hit) begin
        p_v[c_ppick] = 1; p_o[c_ppick] = c_hidx;
        st_put(c_hidx);
      end else begin
        m_v[c_fpick] = 1; m_tag[c_fpick] = req_waddr[AW-3:3];
        m_got[c_fpick] = 0; m_od[c_fpick] = '0; m_om[c_fpick] = '0;
        st_put(c_fpick);
        e_rd = 1; e_rd_line = req_waddr[AW-3:3]; e_rd_idx = c_fpick;
      end
    end
  endtask

  task automatic cyc();
    #1;
    predict();
    chk("req_stall", req_stall, c_stall);
    @(posedge clk);
    apply();
    @(negedge clk);
    chk("rd_valid", rd_valid, e_rd);
    if (e_rd) begin
      chk("rd_line", rd_line, e_rd_line);
      chk("rd_idx", rd_idx, e_rd_idx[FIW-1:0]);
    end
    chk("line_valid", line_valid, e_lv);
    if (e_lv) begin
      chk("line_addr", line_addr, e_la);
      chk("line_data", line_data, e_ld);
    end
    req_valid = 0; rsp_valid = 0;
  endtask

  task automatic req(logic [LW-1:0] l, logic [2:0] w, logic [31:0] d, logic [3:0] be,
                     bit c = 1, bit wa = 1);
    req_valid = 1; req_waddr = {l, w}; req_data = d; req_be = be;
    req_cacheable = c; req_walloc = wa;
  endtask

  task automatic rsp(int idx, int w);
    rsp_valid = 1; rsp_idx = FIW'(idx); rsp_word = 3'(w);
    rsp_data = mem_word(m_tag[idx], w);
  endtask

  task automatic finish_line(int idx, int last_with_req);
    for (int k = 0; k < 8; k++) begin
      rsp(idx, (k * 3 + 1) % 8);
      if (k == 7 && last_with_req != 0) ; // caller drives the request before the last word
      if (k < 7 || last_with_req == 0) cyc();
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", tag);
      summary();
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] la, lb, lc, ld, le, lf;
    la = line_of(0); lb = line_of(1); lc = line_of(2);
    ld = line_of(3); le = line_of(4); lf = line_of(5);

    // R1: reset state
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("rd_valid in reset", rd_valid, 0);
    chk("line_valid in reset", line_valid, 0);
    chk("req_stall in reset", req_stall, 0);
    rst = 0;
    cyc(); cyc();

    // R2: non-allocating requests leave no trace
    tag = "R2";
    req(la, 3'd3, 32'hdead_beef, 4'hf, 0, 1); cyc();
    req(la, 3'd3, 32'hdead_beef, 4'hf, 1, 0); cyc();
    req(la, 3'd1, 32'h1234_5678, 4'hf, 0, 0); cyc();

    // R3: new line fetch, R9 byte lanes
    tag = "R3";
    req(la, 3'd3, 32'h1122_3344, 4'b0101); cyc();
    // R6: out-of-order words with a repeat
    tag = "R6";
    for (int k = 0; k < 7; k++) begin rsp(0, (k * 3 + 1) % 8); cyc(); end
    rsp(0, 7); rsp_data = 32'hffff_0000; cyc();
    // R7: last word completes the line
    tag = "R7";
    rsp(0, 6); cyc();

    // R4: pending merges on an outstanding line
    tag = "R4";
    req(lb, 3'd3, 32'haabb_ccdd, 4'hf); cyc();
    req(lb, 3'd3, 32'h0102_0304, 4'b0011); cyc();
    tag = "R9";
    req(lb, 3'd6, 32'hf000_0000, 4'b1000); cyc();
    tag = "R4";
    req(lb, 3'd0, 32'h0bad_f00d, 4'b0110); cyc();
    // R5: pending buffer full
    tag = "R5";
    req(lb, 3'd1, 32'h5555_5555, 4'hf); cyc();
    tag = "R3";
    req(lc, 3'd2, 32'hc0c0_c0c0, 4'hf); cyc();
    req(ld, 3'd5, 32'hd0d0_d0d0, 4'hf); cyc();
    req(le, 3'd7, 32'he0e0_e0e0, 4'hf); cyc();
    // R5: fill buffer full
    tag = "R5";
    req(lf, 3'd0, 32'h1, 4'hf); cyc();
    tag = "R2";
    req(lf, 3'd0, 32'h1, 4'hf, 0, 1); cyc();

    // R8: completion frees slots; same-cycle miss to the completing line
    tag = "R6";
    for (int k = 0; k < 8; k++) begin rsp(1, (k * 5 + 2) % 8); cyc(); end
    for (int k = 0; k < 7; k++) begin rsp(0, (k * 3 + 1) % 8); cyc(); end
    tag = "R8";
    rsp(0, 6);
    req(lb, 3'd2, 32'h7777_8888, 4'b1100);
    cyc();
    req(lb, 3'd5, 32'h2222_3333, 4'hf); cyc();
    req(lb, 3'd4, 32'h4444_5555, 4'b0001); cyc();
    req(lb, 3'd7, 32'h6666_7777, 4'b1000); cyc();

    // mixed random traffic
    tag = "R7";
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 10 < 6)
        req(line_of(int'($urandom % 6)), 3'($urandom), $urandom, 4'($urandom),
            ($urandom % 8) != 0, ($urandom % 8) != 0);
      if ($urandom % 10 < 7) begin
        int s;
        s = int'($urandom % FD);
        for (int t = 0; t < FD; t++)
          if (!rsp_valid && m_v[(s + t) % FD]) rsp((s + t) % FD, int'($urandom % 8));
      end
      cyc();
    end

    // drain everything
    tag = "R6";
    for (int i = 0; i < FD; i++)
      for (int w = 0; w < 8; w++)
        if (m_v[i] && !m_got[i][w]) begin rsp(i, w); cyc(); end
    cyc();

    finished = 1;
    summary();
    $finish;
  end
endmodule